// File: doc/BRIEF.md
# Interlaced Field Capture Write Controller

This block takes an 8-bit digital video byte stream that carries ITU-R BT.656 timing reference codes. It works out which field is arriving and which lines hold active picture, and it writes the active bytes to memory as bus-master word writes. Each field starts at its own base address and steps by a shared line pitch. Software sets the even base one line above the odd base and sets the pitch to two lines, so the two fields land interleaved as one progressive frame.

Software drives a start and a stop command, a field interrupt enable and a write-one clear for the interrupt. It also supplies the two base addresses and the pitch. A start takes effect only at the start of the next field, and a stop takes effect at the end of the current field. The block raises a sticky interrupt at every completed field. A status bit gives the parity of the field that finished, so software can swap each parity's buffer on its own (ping-pong). The base inputs are sampled only when a field starts, so they may be rewritten while capture is running.

Top module: `weave_field_writer`

## Requirements
- R1: A timing code is the byte run FF 00 00 XY. In XY, bit 6 is the field flag F, bit 5 is the blanking flag V and bit 4 is H (0 = start of active video, 1 = end of active video); the other XY bits are ignored. Capture covers only the bytes after a start code with V=0, up to the next timing code. Bytes of value 0x00 or 0xFF are reserved and are never stored.
- R2: Captured bytes are packed four to a 32-bit word, the first byte in bits 7:0. Each word goes out as one request with an address and data. One word moves per cycle in which wr_req and wr_ack are both high, in capture order, and the request holds steady until it is acknowledged.
- R3: At the first active line of a field the line address loads from odd_base when F=0 or from even_base when F=1. It grows by line_pitch at the end of each active line. Word k of a line is written at line address + 4*k.
- R4: A line whose byte count is not a multiple of four ends with a partial word, padded with zero bytes in the upper lanes.
- R5: While a field is in progress, wr_req is raised only when the word FIFO holds at least 32 bytes (8 words).
- R6: A field ends when a timing code has V=1 and the previous code had V=0. At that point every word still held is requested until the FIFO is empty.
- R7: After cap_start, writing waits for the next field start (a code with V=0 following a code with V=1). No line of a field already in progress is written, and cap_active rises only at a field start.
- R8: At each captured field end with irq_en high, irq is set and stays set until an irq_clr pulse clears it. When irq_en is low at the field end, irq is not set.
- R9: last_field takes the F value (0 = odd, 1 = even) of the most recently completed captured field.
- R10: odd_base and even_base are sampled only at a field start. A change made during a field applies from the next field of that parity.
- R11: cap_stop lets the current field finish. cap_active falls at that field's end and the next field is not written.
- R12: After reset: wr_req=0, irq=0, last_field=0, cap_active=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_valid | input | 1 | vid_byte is valid this cycle |
| vid_byte | input | 8 | Video stream byte |
| cap_start | input | 1 | Pulse: arm capture for the next field |
| cap_stop | input | 1 | Pulse: end capture after the current field |
| irq_en | input | 1 | Field-complete interrupt enable |
| irq_clr | input | 1 | Pulse: clear the interrupt (write-one-to-clear) |
| odd_base | input | ADDR_W | Start address of odd-field (F=0) lines |
| even_base | input | ADDR_W | Start address of even-field (F=1) lines |
| line_pitch | input | ADDR_W | Address step between lines of one field |
| wr_req | output | 1 | Word write request |
| wr_addr | output | ADDR_W | Byte address of the requested word |
| wr_data | output | 8*BPW | Data of the requested word |
| wr_ack | input | 1 | Memory accepts the requested word |
| irq | output | 1 | Sticky field-complete interrupt |
| last_field | output | 1 | Parity of the last completed captured field |
| cap_active | output | 1 | Field capture is running |

## Verification
The bench issues a start in the middle of a field. A controller that starts at once would write stray lines from that field's tail, and the scoreboard reports them as unexpected words. Lines of ten bytes, with a reserved 0xFF byte inserted, catch a packer that stores the reserved byte or drops the zero-padded tail word. A base rewrite made mid-field and checked in the next field of the same parity catches bases that are sampled live. Probes just below and at the 8-word level catch an early or late request. A stop, and a field end with the interrupt disabled, catch a capture that runs past its field or an interrupt that ignores the enable.

// File: rtl/wfw_pkg.sv
package wfw_pkg;
   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_ARMED = 2'd1,
      CAP_RUN   = 2'd2
   } cap_state_e;

   // decoded flags of one timing reference code
   typedef struct packed {
      logic fld;
      logic vblank;
      logic eav;
   } trc_bits_t;

   localparam logic [7:0] SYNC_ONES  = 8'hFF;
   localparam logic [7:0] SYNC_ZEROS = 8'h00;
endpackage

// File: rtl/wfw_trc_decode.sv
module wfw_trc_decode
   import wfw_pkg::*;
#(
   parameter int FLD_BIT = 6,
   parameter int VBL_BIT = 5,
   parameter int EAV_BIT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic       code_hit,
   output trc_bits_t  trc,
   output logic       reserved
);
   localparam int HIST = 3;

   generate
      if (FLD_BIT > 7 || VBL_BIT > 7 || EAV_BIT > 7) begin : g_bad_bits
         $error("timing code flag positions must lie inside one byte");
      end
   endgenerate

   logic [HIST-1:0][7:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= '0;
      else if (in_valid) hist <= {hist[HIST-2:0], in_byte};
   end

   assign code_hit = in_valid && (hist[2] == SYNC_ONES) &&
                     (hist[1] == SYNC_ZEROS) && (hist[0] == SYNC_ZEROS);
   assign trc.fld    = in_byte[FLD_BIT];
   assign trc.vblank = in_byte[VBL_BIT];
   assign trc.eav    = in_byte[EAV_BIT];
   assign reserved   = (in_byte == SYNC_ONES) || (in_byte == SYNC_ZEROS);
endmodule

// File: rtl/wfw_line_packer.sv
module wfw_line_packer #(
   parameter int ADDR_W = 24,
   parameter int BPW    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                field_load,
   input  logic [ADDR_W-1:0]   load_base,
   input  logic [ADDR_W-1:0]   pitch,
   input  logic                pix_valid,
   input  logic [7:0]          pix_byte,
   input  logic                line_end,
   output logic                push,
   output logic [ADDR_W-1:0]   push_addr,
   output logic [8*BPW-1:0]    push_data
);
   localparam int CNT_W = (BPW > 1) ? $clog2(BPW) : 1;

   generate
      if (BPW < 2 || (BPW & (BPW - 1)) != 0) begin : g_bad_bpw
         $error("BPW must be a power of two of at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0]    line_addr;
   logic [ADDR_W-1:0]    word_off;
   logic [BPW-1:0][7:0]  lanes;
   logic [CNT_W-1:0]     fill;
   logic                 full_word;
   logic                 partial;

   assign full_word = pix_valid && (fill == CNT_W'(BPW - 1));
   assign partial   = line_end && (fill != '0);
   assign push      = full_word || partial;
   assign push_addr = line_addr + word_off;

   generate
      for (genvar l = 0; l < BPW; l++) begin : g_lane
         assign push_data[8*l +: 8] =
            (pix_valid && fill == CNT_W'(l)) ? pix_byte : lanes[l];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_addr <= '0;
         word_off  <= '0;
         lanes     <= '0;
         fill      <= '0;
      end else if (field_load) begin
         line_addr <= load_base;
         word_off  <= '0;
         lanes     <= '0;
         fill      <= '0;
      end else if (line_end) begin
         line_addr <= line_addr + pitch;
         word_off  <= '0;
         lanes     <= '0;
         fill      <= '0;
      end else if (pix_valid) begin
         if (full_word) begin
            lanes    <= '0;
            fill     <= '0;
            word_off <= word_off + ADDR_W'(BPW);
         end else begin
            lanes[fill] <= pix_byte;
            fill        <= fill + 1'b1;
         end
      end
   end

   // R3
   line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_load |=> (push_addr == $past(load_base)));

   // R3
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && !field_load) |=> (push_addr == $past(push_addr - word_off + pitch)));
endmodule

// File: rtl/wfw_word_fifo.sv
module wfw_word_fifo #(
   parameter int WIDTH  = 56,
   parameter int DEPTH  = 16,
   parameter int THRESH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             drain,
   input  logic             ack,
   output logic             req,
   output logic [WIDTH-1:0] head,
   output logic             empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (THRESH < 1 || THRESH > DEPTH) begin : g_bad_thresh
         $error("THRESH must lie in 1..DEPTH");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;
   logic             full, push_ok, pop;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign req     = (cnt >= CNT_W'(THRESH)) || (drain && !empty);
   assign pop     = req && ack;
   assign push_ok = push && !full;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop)     rp <= rp + 1'b1;
         cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop);
      end
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R5
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req) && !drain) |-> $past(push));

   // R2
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(head)));
endmodule

// File: rtl/weave_field_writer.sv
module weave_field_writer
   import wfw_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int BPW          = 4,
   parameter int THRESH_BYTES = 32,
   parameter int FIFO_DEPTH   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vid_valid,
   input  logic [7:0]          vid_byte,
   input  logic                cap_start,
   input  logic                cap_stop,
   input  logic                irq_en,
   input  logic                irq_clr,
   input  logic [ADDR_W-1:0]   odd_base,
   input  logic [ADDR_W-1:0]   even_base,
   input  logic [ADDR_W-1:0]   line_pitch,
   output logic                wr_req,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [8*BPW-1:0]    wr_data,
   input  logic                wr_ack,
   output logic                irq,
   output logic                last_field,
   output logic                cap_active
);
   localparam int WORD_W       = 8 * BPW;
   localparam int THRESH_WORDS = THRESH_BYTES / BPW;
   localparam int ENTRY_W      = ADDR_W + WORD_W;

   generate
      if (THRESH_BYTES % BPW != 0) begin : g_bad_thresh
         $error("THRESH_BYTES must be a whole number of words");
      end
   endgenerate

   cap_state_e state;
   trc_bits_t  trc;
   logic code_hit, reserved;
   logic prev_v, in_line, cur_f, stop_pend, drain, irq_q;
   logic field_begin, field_end, field_end_run, go_run;
   logic pix_valid, line_end;
   logic pk_push, fifo_empty;
   logic [ADDR_W-1:0]  pk_addr, load_base;
   logic [WORD_W-1:0]  pk_data;
   logic [ENTRY_W-1:0] fifo_head;

   wfw_trc_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (vid_valid),
      .in_byte  (vid_byte),
      .code_hit (code_hit),
      .trc      (trc),
      .reserved (reserved)
   );

   assign field_begin   = code_hit && !trc.vblank && prev_v;
   assign field_end     = code_hit && trc.vblank && !prev_v;
   assign field_end_run = field_end && (state == CAP_RUN);
   assign go_run        = field_begin &&
                          ((state == CAP_ARMED && !cap_stop) || state == CAP_RUN);
   assign load_base     = trc.fld ? even_base : odd_base;
   assign pix_valid     = vid_valid && in_line && !code_hit && !reserved;
   assign line_end      = code_hit && in_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CAP_IDLE;
         stop_pend <= 1'b0;
      end else begin
         unique case (state)
            CAP_IDLE:  if (cap_start) state <= CAP_ARMED;
            CAP_ARMED: begin
               if (cap_stop)         state <= CAP_IDLE;
               else if (field_begin) state <= CAP_RUN;
            end
            CAP_RUN:   if (field_end && (stop_pend || cap_stop)) state <= CAP_IDLE;
            default:   state <= CAP_IDLE;
         endcase
         if (state != CAP_RUN) stop_pend <= 1'b0;
         else if (cap_stop)    stop_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_v     <= 1'b0;
         in_line    <= 1'b0;
         cur_f      <= 1'b0;
         last_field <= 1'b0;
         irq_q      <= 1'b0;
         drain      <= 1'b0;
      end else begin
         if (code_hit) begin
            prev_v  <= trc.vblank;
            in_line <= !trc.eav && !trc.vblank && (state == CAP_RUN || go_run);
         end
         if (go_run) cur_f <= trc.fld;
         if (field_end_run) last_field <= cur_f;
         if (field_end_run && irq_en) irq_q <= 1'b1;
         else if (irq_clr)            irq_q <= 1'b0;
         if (field_end_run)                drain <= 1'b1;
         else if (fifo_empty && !pk_push)  drain <= 1'b0;
      end
   end

   wfw_line_packer #(.ADDR_W(ADDR_W), .BPW(BPW)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .field_load (go_run),
      .load_base  (load_base),
      .pitch      (line_pitch),
      .pix_valid  (pix_valid),
      .pix_byte   (vid_byte),
      .line_end   (line_end),
      .push       (pk_push),
      .push_addr  (pk_addr),
      .push_data  (pk_data)
   );

   wfw_word_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH), .THRESH(THRESH_WORDS)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (pk_push),
      .push_data ({pk_addr, pk_data}),
      .drain     (drain),
      .ack       (wr_ack),
      .req       (wr_req),
      .head      (fifo_head),
      .empty     (fifo_empty)
   );

   assign wr_addr    = fifo_head[ENTRY_W-1 -: ADDR_W];
   assign wr_data    = fifo_head[WORD_W-1:0];
   assign irq        = irq_q;
   assign cap_active = (state == CAP_RUN);

   // R7
   arm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_active) |-> $past(field_begin));

   // R11
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_active) |-> $past(field_end));

   // R1
   capture_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pk_push |-> cap_active);

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !field_end) |=> !irq);

   // R9
   last_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_end_run |=> (last_field == $past(cur_f)));
endmodule

// File: tb/weave_field_writer_bench.sv
module weave_field_writer_bench;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vid_valid = 1'b0;
   logic [7:0]    vid_byte = 8'h80;
   logic          cap_start = 1'b0, cap_stop = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
   logic [AW-1:0] odd_base = 24'h001000, even_base = 24'h001100, line_pitch = 24'h000200;
   logic          wr_req, wr_ack = 1'b0, irq, last_field, cap_active;
   logic [AW-1:0] wr_addr;
   logic [31:0]   wr_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [AW+31:0] exp_q[$];
   string          tag_q[$];

   always #5 clk = ~clk;

   weave_field_writer u_weave_field_writer (
      .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_byte(vid_byte),
      .cap_start(cap_start), .cap_stop(cap_stop), .irq_en(irq_en), .irq_clr(irq_clr),
      .odd_base(odd_base), .even_base(even_base), .line_pitch(line_pitch),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .irq(irq), .last_field(last_field), .cap_active(cap_active)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // monitor: scoreboard of written words (R2)
   always @(negedge clk) begin
      if (rst_n && wr_req) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected word actual=%h/%h expected=none", wr_addr, wr_data);
         end else begin
            logic [AW+31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({wr_addr, wr_data} !== e) begin
               n_fail++;
               $display("FAIL %s word actual=%h/%h expected=%h/%h", t, wr_addr, wr_data,
                        e[AW+31:32], e[31:0]);
            end
         end
      end
      wr_ack <= rst_n && wr_req;
   end

   // kind: 0 none, 1 start, 2 stop, 3 irq clear
   task automatic send_ctl(input logic [7:0] b, input int kind);
      @(negedge clk);
      vid_byte  = b;
      vid_valid = 1'b1;
      cap_start = (kind == 1);
      cap_stop  = (kind == 2);
      irq_clr   = (kind == 3);
      @(posedge clk);
      #2;
      vid_valid = 1'b0;
      cap_start = 1'b0;
      cap_stop  = 1'b0;
      irq_clr   = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      send_ctl(b, 0);
   endtask

   task automatic send_code(input logic f, input logic v, input logic h);
      send_byte(8'hFF);
      send_byte(8'h00);
      send_byte(8'h00);
      send_byte({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h});
   endtask

   task automatic blank(input int n);
      for (int i = 0; i < n; i++) send_byte((i % 2 == 0) ? 8'h80 : 8'h10);
   endtask

   function automatic logic [7:0] pix(input int seed, input int ln, input int i);
      return 8'(32 + ((seed * 29 + ln * 11 + i * 7) % 192));
   endfunction

   task automatic exp_push(input logic [AW-1:0] a, input logic [31:0] d, input string t);
      exp_q.push_back({a, d});
      tag_q.push_back(t);
   endtask

   task automatic send_head(input logic f);
      send_code(f, 1'b1, 1'b1);
      blank(16);
      send_code(f, 1'b1, 1'b0);
      blank(4);
   endtask

   // act after line 0: 0 none, 1 start, 2 stop, 3 new odd base
   task automatic send_body(input logic f, input bit cap, input int nl, input int len,
                            input logic [AW-1:0] base, input int seed, input bit rsv,
                            input bit thr, input int act, input string tag);
      for (int ln = 0; ln < nl; ln++) begin
         logic [31:0] acc;
         int nb, w;
         logic [7:0] b;
         acc = '0; nb = 0; w = 0;
         send_code(f, 1'b0, 1'b0);
         for (int i = 0; i < len; i++) begin
            if (rsv && ln == 1 && i == 3) send_byte(8'hFF);
            b = pix(seed, ln, i);
            send_byte(b);
            if (cap) begin
               acc[8*nb +: 8] = b;
               nb++;
               if (nb == 4) begin
                  exp_push(base + AW'(ln) * line_pitch + AW'(4 * w), acc, tag);
                  acc = '0; nb = 0; w++;
               end
            end
            // R5: eighth word held raises the request
            if (thr && ln == 1 && i == 3) chk(wr_req == 1'b1, "R5 request at 32 bytes", 32'(wr_req), 32'd1);
         end
         send_code(f, 1'b0, 1'b1);
         if (cap && nb != 0) exp_push(base + AW'(ln) * line_pitch + AW'(4 * w), acc, tag);
         // R5: seven words held, no request yet
         if (thr && ln == 0) chk(wr_req == 1'b0, "R5 no request below 32 bytes", 32'(wr_req), 32'd0);
         if (ln == 0 && act == 1) send_ctl(8'h80, 1);
         if (ln == 0 && act == 2) send_ctl(8'h80, 2);
         if (ln == 0 && act == 3) odd_base = 24'h004000;
         blank(4);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R12 reset state
      chk(wr_req == 1'b0, "R12 wr_req", 32'(wr_req), 0);
      chk(irq == 1'b0, "R12 irq", 32'(irq), 0);
      chk(last_field == 1'b0, "R12 last_field", 32'(last_field), 0);
      chk(cap_active == 1'b0, "R12 cap_active", 32'(cap_active), 0);
      rst_n = 1'b1;
      irq_en = 1'b1;
      blank(4);

      // field A: start issued mid-field, nothing written (R7)
      send_head(1'b0);
      send_body(1'b0, 1'b0, 2, 8, '0, 1, 1'b0, 1'b0, 1, "R7");
      chk(cap_active == 1'b0, "R7 not active mid-field", 32'(cap_active), 0);

      // field B (even): first captured field
      send_head(1'b1);
      chk(irq == 1'b0, "R8 no irq for uncaptured field", 32'(irq), 0);
      chk(cap_active == 1'b0, "R7 waits for field start", 32'(cap_active), 0);
      send_body(1'b1, 1'b1, 2, 8, 24'h001100, 2, 1'b0, 1'b0, 0, "R2");
      chk(cap_active == 1'b1, "R7 active after field start", 32'(cap_active), 1);
      chk(wr_req == 1'b0, "R5 four words held, no request", 32'(wr_req), 0);

      // field C (odd): partial words, reserved byte, mid-field base change
      send_head(1'b0);
      chk(irq == 1'b1, "R8 irq after even field", 32'(irq), 1);
      chk(last_field == 1'b1, "R9 even field completed", 32'(last_field), 1);
      send_ctl(8'h80, 3);
      chk(irq == 1'b0, "R8 irq cleared", 32'(irq), 0);
      send_body(1'b0, 1'b1, 3, 10, 24'h001000, 3, 1'b1, 1'b0, 3, "R1,R4");

      // field D (even): threshold probes, stop issued, irq disabled
      send_head(1'b1);
      chk(irq == 1'b1, "R8 irq after odd field", 32'(irq), 1);
      chk(last_field == 1'b0, "R9 odd field completed", 32'(last_field), 0);
      send_ctl(8'h80, 3);
      irq_en = 1'b0;
      send_body(1'b1, 1'b1, 2, 28, 24'h001100, 4, 1'b0, 1'b1, 2, "R5");
      chk(cap_active == 1'b1, "R11 field finishes after stop", 32'(cap_active), 1);

      // field E (odd): not captured after stop; restart issued mid-field
      send_head(1'b0);
      chk(cap_active == 1'b0, "R11 inactive after stop", 32'(cap_active), 0);
      chk(irq == 1'b0, "R8 disabled irq stays low", 32'(irq), 0);
      chk(last_field == 1'b1, "R9 even field completed", 32'(last_field), 1);
      send_body(1'b0, 1'b0, 2, 8, '0, 5, 1'b0, 1'b0, 1, "R11");

      // field F (even)
      send_head(1'b1);
      send_body(1'b1, 1'b1, 1, 12, 24'h001100, 6, 1'b0, 1'b0, 0, "R3");
      irq_en = 1'b1;

      // field G (odd): uses base rewritten during field C
      send_head(1'b0);
      chk(last_field == 1'b1, "R9 even field completed", 32'(last_field), 1);
      send_body(1'b0, 1'b1, 2, 8, 24'h004000, 7, 1'b0, 1'b0, 0, "R10");

      send_code(1'b0, 1'b1, 1'b1);
      blank(30);
      chk(irq == 1'b1, "R8 irq after final field", 32'(irq), 1);
      chk(last_field == 1'b0, "R9 odd field completed", 32'(last_field), 0);
      chk(exp_q.size() == 0, "R6 all words drained", 32'(exp_q.size()), 0);
      chk(wr_req == 1'b0, "R6 request drops when empty", 32'(wr_req), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule